// File: doc/BRIEF.md
# Hash Engine Control Front-End

This block is the register-mapped control and status front-end that sits between software and a multi-algorithm hash core. Software programs a source address, a digest buffer address, a key buffer address and a byte length, then writes a command word. That write launches a job: the block snapshots the programmed values, decodes the algorithm, accumulate and byte-order fields of the command, and hands all of them to the core with a one-cycle start pulse.

While the core works, a busy flag in the status register is set and further command writes are refused and flagged as overruns. When the core reports completion, busy drops and a completion flag rises in the same cycle. The completion flag drives a level interrupt pin and stays set until software writes a one to it. Software is expected to clear that flag before each launch and poll it with a timeout that grows with the job length. The hashing datapath and memory transfers live in the core and are not part of this block.

Top module: `hash_regfront`

## Requirements
- R1: After a synchronous active-low reset every register reads zero, busy, completion and overrun flags are clear, and `irq` and `core_start` are low.
- R2: Offsets 0x20 (source address), 0x24 (digest address), 0x28 (key address) and 0x2C (byte length) read back the last value written. Reads of unmapped offsets return zero.
- R3: A write to the command register (offset 0x30) with busy clear and a recognised algorithm makes busy read one and `core_start` high for exactly one cycle, both starting in the cycle after the write. The core outputs carry the values captured at that write, and later register writes do not change them during the job.
- R4: The algorithm is the command bit group {10,6,5,4}: 0010 is SHA-1 (`core_algo`=0), 0101 is SHA-256 (1), 1110 is SHA-384 (2), 0110 is SHA-512 (3). Command bit 8 drives `core_accum` and bit 3 drives `core_big_endian`.
- R5: A command write whose algorithm group matches none of the four codes does not start the core, leaves busy clear and the command readback unchanged, and sets the overrun flag.
- R6: A command write while busy is ignored: no further start pulse, the command readback keeps the last accepted word, and the overrun flag sets.
- R7: `core_done` while busy clears busy and sets the completion flag in the same following cycle. `core_done` while idle changes nothing.
- R8: The completion flag holds until a status write with bit 9 set; a status write with bit 9 clear leaves it. The overrun flag clears the same way through bit 23. `irq` always equals the completion flag.
- R9: When `core_done` and a status write clearing the completion flag fall in the same cycle, the flag ends set.
- R10: The status register (offset 0x1C) reads busy in bit 0, completion in bit 9, overrun in bit 23 and zero in every other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| core_start | output | 1 | One-cycle job launch pulse |
| core_algo | output | 2 | Decoded algorithm code |
| core_accum | output | 1 | Accumulate mode for the job |
| core_big_endian | output | 1 | Byte-order handling enable |
| core_src_addr | output | 32 | Captured source address |
| core_dig_addr | output | 32 | Captured digest buffer address |
| core_key_addr | output | 32 | Captured key buffer address |
| core_len | output | 32 | Captured byte length |
| core_done | input | 1 | Job completion from the core |
| irq | output | 1 | Level interrupt, equals the completion flag |

## Verification
Two pairs of events can meet in one clock: the core's completion with a software clear of the completion flag, and the core's completion with a fresh command write. The bench provokes both by raising `core_done` in the very cycle it drives the bus write. It judges the first by requiring the flag to end set with busy clear, and the second by requiring the command to be refused with the overrun flag set, with no start pulse and an unchanged command readback, since busy was still set when the write was sampled.

// File: rtl/hashfe_pkg.sv
// Shared constants and types for the hash front-end.
// Assumes byte offsets on an 8-bit register address.
package hashfe_pkg;
    localparam logic [7:0] OFS_STATUS = 8'h1C;
    localparam logic [7:0] OFS_BANK   = 8'h20;
    localparam logic [7:0] OFS_CMD    = 8'h30;

    localparam int STS_BUSY_BIT = 0;
    localparam int STS_DONE_BIT = 9;
    localparam int STS_OVR_BIT  = 23;

    localparam int CMD_BE_BIT    = 3;
    localparam int CMD_ACCUM_BIT = 8;

    typedef enum logic [1:0] {
        ALG_SHA1   = 2'd0,
        ALG_SHA256 = 2'd1,
        ALG_SHA384 = 2'd2,
        ALG_SHA512 = 2'd3
    } hash_alg_t;

    typedef struct packed {
        logic      ok;
        hash_alg_t alg;
        logic      accum;
        logic      big_endian;
    } cmd_fields_t;
endpackage

// File: rtl/hashfe_cmd_decode.sv
// Decodes a command word into algorithm and mode fields.
// Assumes the algorithm group is bits {10,6,5,4}; any other pattern is invalid.
module hashfe_cmd_decode
    import hashfe_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] cmd,
    output cmd_fields_t       fields
);
    logic [3:0] grp;

    // Pick the algorithm group and classify it.
    always_comb begin
        grp = {cmd[10], cmd[6], cmd[5], cmd[4]};
        fields.accum      = cmd[CMD_ACCUM_BIT];
        fields.big_endian = cmd[CMD_BE_BIT];
        fields.ok         = 1'b1;
        fields.alg        = ALG_SHA1;
        case (grp)
            4'b0010: fields.alg = ALG_SHA1;
            4'b0101: fields.alg = ALG_SHA256;
            4'b1110: fields.alg = ALG_SHA384;
            4'b0110: fields.alg = ALG_SHA512;
            default: fields.ok  = 1'b0;
        endcase
    end
endmodule

// File: rtl/hashfe_job_ctrl.sv
// Job sequencer: busy flag, launch pulse, completion and overrun flags.
// Assumes launch_req is a command write strobe and cmd_ok its decode result.
module hashfe_job_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic launch_req,
    input  logic cmd_ok,
    input  logic core_done,
    input  logic clr_done,
    input  logic clr_ovr,
    output logic accept,
    output logic busy,
    output logic start,
    output logic done_flag,
    output logic ovr_flag
);
    logic busy_q, start_q, done_q, ovr_q;

    // A launch is taken only when idle and the command decodes.
    assign accept = launch_req && !busy_q && cmd_ok;

    // Flag and pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            start_q <= 1'b0;
            done_q  <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            start_q <= accept;
            if (accept)
                busy_q <= 1'b1;
            else if (core_done)
                busy_q <= 1'b0;
            if (busy_q && core_done)
                done_q <= 1'b1;
            else if (clr_done)
                done_q <= 1'b0;
            if (launch_req && !accept)
                ovr_q <= 1'b1;
            else if (clr_ovr)
                ovr_q <= 1'b0;
        end
    end

    assign busy      = busy_q;
    assign start     = start_q;
    assign done_flag = done_q;
    assign ovr_flag  = ovr_q;

    // R3
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |=> !start_q);
    // R3
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> start_q);
    // R7
    done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && core_done) |=> (!busy_q && done_q));
    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !clr_done) |=> done_q);
    // R9
    done_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && core_done && clr_done) |=> done_q);
    // R6
    busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_req && busy_q) |=> (ovr_q && !start_q));
endmodule

// File: rtl/hashfe_addr_bank.sv
// Bank of writable parameter registers with a job snapshot of each.
// Assumes consecutive word offsets starting at BASE; snapshot on capture.
module hashfe_addr_bank #(
    parameter int         NREG   = 4,
    parameter int         DATA_W = 32,
    parameter int         ADDR_W = 8,
    parameter logic [7:0] BASE   = 8'h20
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    input  logic                         capture,
    output logic                         rd_hit,
    output logic [DATA_W-1:0]            rd_data,
    output logic [NREG-1:0][DATA_W-1:0]  job_q
);
    localparam int STRIDE = DATA_W / 8;

    logic [NREG-1:0][DATA_W-1:0] live_q;
    logic [NREG-1:0]             sel;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [ADDR_W-1:0] OFS = ADDR_W'(int'(BASE) + i * STRIDE);
        assign sel[i] = (addr == OFS);

        // Software-visible copy.
        always_ff @(posedge clk) begin
            if (!rst_n)
                live_q[i] <= '0;
            else if (wr && sel[i])
                live_q[i] <= wdata;
        end

        // Snapshot handed to the core at launch.
        always_ff @(posedge clk) begin
            if (!rst_n)
                job_q[i] <= '0;
            else if (capture)
                job_q[i] <= live_q[i];
        end
    end

    // Read mux over the bank.
    always_comb begin
        rd_hit  = |sel;
        rd_data = '0;
        for (int k = 0; k < NREG; k++)
            if (sel[k])
                rd_data = live_q[k];
    end
endmodule

// File: rtl/hash_regfront.sv
// Register front-end for a hash core: status, parameter bank, command.
// Assumes single-cycle writes; reads are combinational on bus_addr.
module hash_regfront
    import hashfe_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int NPARAM = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              core_start,
    output logic [1:0]        core_algo,
    output logic              core_accum,
    output logic              core_big_endian,
    output logic [DATA_W-1:0] core_src_addr,
    output logic [DATA_W-1:0] core_dig_addr,
    output logic [DATA_W-1:0] core_key_addr,
    output logic [DATA_W-1:0] core_len,
    input  logic              core_done,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(OFS_CMD);

    logic                        cmd_wr, sts_wr, accept;
    logic                        busy, done_flag, ovr_flag;
    logic [DATA_W-1:0]           cmd_q;
    cmd_fields_t                 wr_fields, job_fields;
    logic                        bank_hit;
    logic [DATA_W-1:0]           bank_rd;
    logic [NPARAM-1:0][DATA_W-1:0] job_q;

    assign cmd_wr = bus_wr && (bus_addr == A_CMD);
    assign sts_wr = bus_wr && (bus_addr == A_STATUS);

    hashfe_cmd_decode #(.DATA_W(DATA_W)) u_dec_wr (
        .cmd    (bus_wdata),
        .fields (wr_fields)
    );

    hashfe_cmd_decode #(.DATA_W(DATA_W)) u_dec_job (
        .cmd    (cmd_q),
        .fields (job_fields)
    );

    hashfe_job_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch_req (cmd_wr),
        .cmd_ok     (wr_fields.ok),
        .core_done  (core_done),
        .clr_done   (sts_wr && bus_wdata[STS_DONE_BIT]),
        .clr_ovr    (sts_wr && bus_wdata[STS_OVR_BIT]),
        .accept     (accept),
        .busy       (busy),
        .start      (core_start),
        .done_flag  (done_flag),
        .ovr_flag   (ovr_flag)
    );

    hashfe_addr_bank #(
        .NREG   (NPARAM),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .BASE   (OFS_BANK)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .capture (accept),
        .rd_hit  (bank_hit),
        .rd_data (bank_rd),
        .job_q   (job_q)
    );

    // Last accepted command word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_q <= '0;
        else if (accept)
            cmd_q <= bus_wdata;
    end

    // Register read mux.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_STATUS) begin
            bus_rdata[STS_BUSY_BIT] = busy;
            bus_rdata[STS_DONE_BIT] = done_flag;
            bus_rdata[STS_OVR_BIT]  = ovr_flag;
        end else if (bus_addr == A_CMD) begin
            bus_rdata = cmd_q;
        end else if (bank_hit) begin
            bus_rdata = bank_rd;
        end
    end

    assign core_algo       = job_fields.alg;
    assign core_accum      = job_fields.accum;
    assign core_big_endian = job_fields.big_endian;
    assign core_src_addr   = job_q[0];
    assign core_dig_addr   = job_q[1];
    assign core_key_addr   = job_q[2];
    assign core_len        = job_q[3];
    assign irq             = done_flag;

    // R6
    cmd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy) |=> $stable(cmd_q));
    // R5
    bad_alg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !wr_fields.ok) |=> (!core_start && ovr_flag));
    // R3
    job_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !core_start) |-> $stable(core_src_addr));
endmodule

// File: tb/hash_regfront_bench.sv
module hash_regfront_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        core_start, core_accum, core_big_endian, irq;
    logic [1:0]  core_algo;
    logic [31:0] core_src_addr, core_dig_addr, core_key_addr, core_len;
    logic        core_done = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    hash_regfront u_hash_regfront (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_start(core_start),
        .core_algo(core_algo), .core_accum(core_accum),
        .core_big_endian(core_big_endian), .core_src_addr(core_src_addr),
        .core_dig_addr(core_dig_addr), .core_key_addr(core_key_addr),
        .core_len(core_len), .core_done(core_done), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    // Responder: completion after n cycles.
    task automatic respond(input int n);
        repeat (n) @(negedge clk);
        core_done = 1'b1;
        @(negedge clk);
        core_done = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 start", {31'd0, core_start}, 0);
        check("R1 irq", {31'd0, irq}, 0);
        rd_check("R1 status", 8'h1C, 0);
        rd_check("R1 cmd", 8'h30, 0);
        rd_check("R1 src", 8'h20, 0);
        rd_check("R1 len", 8'h2C, 0);
    endtask

    task automatic t_regs;
        wr(8'h20, 32'h1000_0000);
        wr(8'h24, 32'h2000_0040);
        wr(8'h28, 32'h3000_0080);
        wr(8'h2C, 32'h0000_0040);
        rd_check("R2 src", 8'h20, 32'h1000_0000);
        rd_check("R2 dig", 8'h24, 32'h2000_0040);
        rd_check("R2 key", 8'h28, 32'h3000_0080);
        rd_check("R2 len", 8'h2C, 32'h0000_0040);
        rd_check("R2 unmapped", 8'h04, 0);
    endtask

    task automatic t_main_job;
        wr(8'h30, 32'h0000_0158);   // SHA-256, accum, big-endian
        check("R3 start", {31'd0, core_start}, 1);
        rd_check("R10 busy", 8'h1C, 32'h0000_0001);
        check("R4 alg256", {30'd0, core_algo}, 1);
        check("R4 accum", {31'd0, core_accum}, 1);
        check("R4 be", {31'd0, core_big_endian}, 1);
        check("R3 src", core_src_addr, 32'h1000_0000);
        check("R3 dig", core_dig_addr, 32'h2000_0040);
        check("R3 key", core_key_addr, 32'h3000_0080);
        check("R3 len", core_len, 32'h40);
        wr(8'h20, 32'hDEAD_BEEF);
        check("R3 pulse", {31'd0, core_start}, 0);
        check("R3 snapshot", core_src_addr, 32'h1000_0000);
        wr(8'h30, 32'h0000_0020);   // refused, busy
        check("R6 no start", {31'd0, core_start}, 0);
        rd_check("R6 status", 8'h1C, 32'h0080_0001);
        rd_check("R6 cmd", 8'h30, 32'h0000_0158);
        respond(3);
        rd_check("R7 status", 8'h1C, 32'h0080_0200);
        check("R8 irq pin", {31'd0, irq}, 1);
        wr(8'h1C, 32'h0000_0000);
        rd_check("R8 hold", 8'h1C, 32'h0080_0200);
        wr(8'h1C, 32'h0000_0200);
        rd_check("R8 clr done", 8'h1C, 32'h0080_0000);
        check("R8 irq low", {31'd0, irq}, 0);
        wr(8'h1C, 32'h0080_0000);
        rd_check("R8 clr ovr", 8'h1C, 0);
    endtask

    task automatic t_algos;
        logic [31:0] cmds [3] = '{32'h20, 32'h460, 32'h60};
        logic [1:0]  codes[3] = '{2'd0, 2'd2, 2'd3};
        for (int i = 0; i < 3; i++) begin
            wr(8'h30, cmds[i]);
            check("R4 start", {31'd0, core_start}, 1);
            check("R4 alg", {30'd0, core_algo}, {30'd0, codes[i]});
            check("R4 mode bits", {30'd0, core_accum, core_big_endian}, 0);
            respond(2);
            wr(8'h1C, 32'h200);
        end
        rd_check("R4 idle", 8'h1C, 0);
    endtask

    task automatic t_invalid;
        wr(8'h30, 32'h0000_0070);
        check("R5 no start", {31'd0, core_start}, 0);
        rd_check("R5 status", 8'h1C, 32'h0080_0000);
        rd_check("R5 cmd", 8'h30, 32'h0000_0060);
        @(negedge clk);
        check("R5 still no start", {31'd0, core_start}, 0);
        wr(8'h1C, 32'h0080_0000);
    endtask

    task automatic t_done_idle;
        respond(1);
        rd_check("R7 idle done", 8'h1C, 0);
        check("R7 idle irq", {31'd0, irq}, 0);
    endtask

    task automatic t_collide;
        wr(8'h30, 32'h0000_0050);
        check("R9 start", {31'd0, core_start}, 1);
        @(negedge clk);
        bus_addr = 8'h1C; bus_wdata = 32'h200; bus_wr = 1'b1; core_done = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; core_done = 1'b0;
        rd_check("R9 done wins", 8'h1C, 32'h0000_0200);
        wr(8'h1C, 32'h200);
        wr(8'h30, 32'h0000_0060);
        @(negedge clk);
        bus_addr = 8'h30; bus_wdata = 32'h20; bus_wr = 1'b1; core_done = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; core_done = 1'b0;
        check("R6 collide no start", {31'd0, core_start}, 0);
        rd_check("R6 collide status", 8'h1C, 32'h0080_0200);
        rd_check("R6 collide cmd", 8'h30, 32'h0000_0060);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_main_job();
        t_algos();
        t_invalid();
        t_done_idle();
        t_collide();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule